// File: doc/BRIEF.md
# Complex-Coefficient FIR Iteration Engine

The engine computes one output sample of a finite impulse response filter whose coefficients are complex and whose input samples are real. A start pulse carries an operation code and a parameter set: where the coefficient vector begins, how many taps to use, and the base, size and current pointer of an input ring and of an output ring. All of these sit in a private RAM of 16-bit words. The engine walks the taps, accumulates the real and imaginary products in two wide accumulators, rounds both to 16 bits, writes the complex result into the output ring and then reports the advanced ring pointers. A caller keeps the returned pointers and passes them back with the next start, so a stream of samples is filtered one start at a time.

The RAM has a second, word-addressed side port with a one-cycle read latency. It is used to load coefficients and samples and to collect results. The side port has no arbitration with the engine and must be used only while the engine is idle.

Control is one state machine. `S_IDLE` waits for an accepted start and goes to `S_RD_X`, or to `S_WR_RE` when the tap count is zero. Each tap then passes through `S_RD_X` (sample read), `S_RD_CR` (sample captured, real coefficient read), `S_RD_CI` (real product accumulated, imaginary coefficient read) and `S_MAC` (imaginary product accumulated, pointers stepped). `S_MAC` goes back to `S_RD_X` while taps remain, and to `S_WR_RE` after the last one. `S_WR_RE` writes the real word. `S_WR_IM` writes the imaginary word and loads the reported pointers. `S_DONE` raises done for one cycle and returns to `S_IDLE`.

Top module: `cxfir_engine`

## Requirements
- R1: A start is accepted only when the engine is idle and opcode equals 5'b00101. A start carrying any other opcode leaves busy low, writes nothing and keeps both reported pointers unchanged.
- R2: The output is Y = sum over p in 0..K-1 of C(p)·X(n-p). Coefficient p has its real word at byte address coef_base+4p and its imaginary word at coef_base+4p+2, so C(0) is at the lowest address.
- R3: Sample X(n-p) is read from byte address in_ptr-2p. When a step would fall below in_base, it wraps to in_base+M-1, the last sample of the (M+1)-byte ring.
- R4: Each product is a signed Q15×Q15 value held in a 40-bit accumulator per component. The result is floor((acc+2^14)/2^15), saturated to the range -32768..32767.
- R5: The real result is written at byte address out_ptr and the imaginary result at out_ptr+2.
- R6: The reported output pointer is out_ptr+4. If out_ptr+4 exceeds out_base+N, it is out_base instead.
- R7: The reported input pointer is in_ptr+2. If in_ptr+2 exceeds in_base+M, it is in_base instead.
- R8: Done is high for exactly one cycle, right after the second output write. The reported pointers hold from that cycle until the next accepted start.
- R9: With K=1 the result is C(0)·X(n), rounded once with no other contribution. With K=0 both written words are zero.
- R10: Busy is high from the cycle after an accepted start through the done cycle. A start seen while busy has no effect.
- R11: Busy is high for exactly 4K+2 cycles before the done cycle.
- R12: After reset, busy, done and both reported pointers are zero. A side-port read returns the word one cycle after its address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle |
| opcode | input | 5 | Operation code, must be 5'b00101 |
| coef_base | input | AW | Byte address of C(0) real word |
| tap_cnt | input | KW | Tap count K |
| in_base | input | AW | Input ring base byte address |
| in_size | input | AW | Input ring span M (ring is M+1 bytes) |
| in_ptr | input | AW | Byte address of newest sample X(n) |
| out_base | input | AW | Output ring base byte address |
| out_size | input | AW | Output ring span N (ring is N+1 bytes) |
| out_ptr | input | AW | Byte address for the next output |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| in_ptr_next | output | AW | Advanced input pointer |
| out_ptr_next | output | AW | Advanced output pointer |
| ext_we | input | 1 | Side-port write enable |
| ext_addr | input | AW-1 | Side-port word address |
| ext_wdata | input | 16 | Side-port write data |
| ext_rdata | output | 16 | Side-port read data, one cycle latency |

## Verification
A state machine that skips or repeats a tap stage shows up at the done pulse: the busy length no longer matches 4K+2, and the written words are wrong because a product is missing or doubled. A wrong backward step or wrap of the sample pointer appears only as a wrong output value, and only when the tap window crosses the ring base, so the stimulus places windows on both sides of that edge. Rounding and saturation faults appear in the first result that uses an odd low half or an overflowing sum. Pointer faults appear in the reported pointers in the done cycle, with extra runs placed on the last slot of each ring.

// File: rtl/cxfir_pkg.sv
package cxfir_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_X,
        S_RD_CR,
        S_RD_CI,
        S_MAC,
        S_WR_RE,
        S_WR_IM,
        S_DONE
    } cxfir_state_t;

    localparam logic [4:0] OPC_CXFIR = 5'b00101;

endpackage

// File: rtl/cxfir_ram.sv
module cxfir_ram #(
    parameter int WA = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [WA-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [WA-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int WORDS = 1 << WA;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end

endmodule

// File: rtl/cxfir_ring.sv
module cxfir_ring #(
    parameter int AW       = 10,
    parameter int STEP     = 2,
    parameter bit BACKWARD = 1'b0
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] nxt
);
    localparam logic [AW:0] STEP_W = (AW+1)'(STEP);
    localparam logic [AW:0] ONE_W  = (AW+1)'(1);

    logic [AW:0] p_w, b_w, last_w;

    assign p_w    = {1'b0, ptr};
    assign b_w    = {1'b0, base};
    assign last_w = b_w + {1'b0, span};

    generate
        if (BACKWARD) begin : g_back
            // Below the base: land on the last whole step of the ring.
            always_comb begin
                if (p_w < b_w + STEP_W) nxt = AW'(last_w + ONE_W - STEP_W);
                else                    nxt = AW'(p_w - STEP_W);
            end
        end else begin : g_fwd
            logic [AW:0] up_w;
            assign up_w = p_w + STEP_W;
            always_comb begin
                if (up_w > last_w) nxt = base;
                else               nxt = up_w[AW-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/cxfir_mac.sv
module cxfir_mac #(
    parameter int DW   = 16,
    parameter int ACCW = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en_re,
    input  logic                 en_im,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] c,
    output logic        [DW-1:0] y_re,
    output logic        [DW-1:0] y_im
);
    localparam int PW = 2 * DW;
    localparam logic signed [ACCW-1:0] RND  = {{(ACCW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
    localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] MINV = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic        [1:0]    lane_en;
    logic        [DW-1:0] lane_y [2];

    assign prod    = x * c;
    assign lane_en = {en_im, en_re};
    assign y_re    = lane_y[0];
    assign y_im    = lane_y[1];

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            logic signed [ACCW-1:0] acc, sum, shf;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          acc <= '0;
                else if (clr)        acc <= '0;
                else if (lane_en[g]) acc <= acc + ACCW'(prod);
            end

            assign sum = acc + RND;
            assign shf = sum >>> (DW - 1);

            always_comb begin
                if (shf > MAXV)      lane_y[g] = MAXV[DW-1:0];
                else if (shf < MINV) lane_y[g] = MINV[DW-1:0];
                else                 lane_y[g] = shf[DW-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/cxfir_engine.sv
module cxfir_engine
    import cxfir_pkg::*;
#(
    parameter int AW   = 10,
    parameter int DW   = 16,
    parameter int KW   = 8,
    parameter int ACCW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [4:0]    opcode,
    input  logic [AW-1:0] coef_base,
    input  logic [KW-1:0] tap_cnt,
    input  logic [AW-1:0] in_base,
    input  logic [AW-1:0] in_size,
    input  logic [AW-1:0] in_ptr,
    input  logic [AW-1:0] out_base,
    input  logic [AW-1:0] out_size,
    input  logic [AW-1:0] out_ptr,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] in_ptr_next,
    output logic [AW-1:0] out_ptr_next,
    input  logic          ext_we,
    input  logic [AW-2:0] ext_addr,
    input  logic [DW-1:0] ext_wdata,
    output logic [DW-1:0] ext_rdata
);
    localparam int            WA    = AW - 1;
    localparam logic [AW-1:0] HALF  = AW'(2);
    localparam logic [AW-1:0] CSTEP = AW'(4);
    localparam logic [KW-1:0] K_ONE = KW'(1);

    cxfir_state_t state, nstate;

    logic          accept;
    logic [AW-1:0] cp, xp, x_new, ib, im, ob, on, op;
    logic [AW-1:0] cp_im, op_im, xp_back, x_fwd, op_fwd;
    logic [KW-1:0] k_left;
    logic [DW-1:0] x_q, y_re, y_im;
    logic          eng_we, mac_en_re, mac_en_im;
    logic [WA-1:0] eng_addr;
    logic [DW-1:0] eng_wdata, eng_rdata;

    assign accept = start && (opcode == OPC_CXFIR) && (state == S_IDLE);
    assign cp_im  = cp + HALF;
    assign op_im  = op + HALF;

    cxfir_ram #(.WA(WA), .DW(DW)) u_ram (
        .clk     (clk),
        .a_we    (eng_we),
        .a_addr  (eng_addr),
        .a_wdata (eng_wdata),
        .a_rdata (eng_rdata),
        .b_we    (ext_we),
        .b_addr  (ext_addr),
        .b_wdata (ext_wdata),
        .b_rdata (ext_rdata)
    );

    cxfir_ring #(.AW(AW), .STEP(2), .BACKWARD(1'b1)) u_x_back (
        .ptr (xp), .base (ib), .span (im), .nxt (xp_back)
    );

    cxfir_ring #(.AW(AW), .STEP(2), .BACKWARD(1'b0)) u_x_fwd (
        .ptr (x_new), .base (ib), .span (im), .nxt (x_fwd)
    );

    cxfir_ring #(.AW(AW), .STEP(4), .BACKWARD(1'b0)) u_o_fwd (
        .ptr (op), .base (ob), .span (on), .nxt (op_fwd)
    );

    cxfir_mac #(.DW(DW), .ACCW(ACCW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en_re (mac_en_re),
        .en_im (mac_en_im),
        .x     (x_q),
        .c     (eng_rdata),
        .y_re  (y_re),
        .y_im  (y_im)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Transitions
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (accept) nstate = (tap_cnt == '0) ? S_WR_RE : S_RD_X;
            S_RD_X:  nstate = S_RD_CR;
            S_RD_CR: nstate = S_RD_CI;
            S_RD_CI: nstate = S_MAC;
            S_MAC:   nstate = (k_left == K_ONE) ? S_WR_RE : S_RD_X;
            S_WR_RE: nstate = S_WR_IM;
            S_WR_IM: nstate = S_DONE;
            S_DONE:  nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // Pointers, tap counter, sample register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp <= '0; xp <= '0; x_new <= '0; k_left <= '0;
            ib <= '0; im <= '0; ob <= '0; on <= '0; op <= '0;
            x_q <= '0; in_ptr_next <= '0; out_ptr_next <= '0;
        end else if (accept) begin
            cp <= coef_base; xp <= in_ptr; x_new <= in_ptr; k_left <= tap_cnt;
            ib <= in_base; im <= in_size; ob <= out_base; on <= out_size; op <= out_ptr;
        end else begin
            case (state)
                S_RD_CR: x_q <= eng_rdata;
                S_MAC: begin
                    xp     <= xp_back;
                    cp     <= cp + CSTEP;
                    k_left <= k_left - K_ONE;
                end
                S_WR_IM: begin
                    in_ptr_next  <= x_fwd;
                    out_ptr_next <= op_fwd;
                end
                default: ;
            endcase
        end
    end

    // Outputs per state
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        eng_we    = 1'b0;
        eng_addr  = xp[AW-1:1];
        eng_wdata = y_re;
        mac_en_re = 1'b0;
        mac_en_im = 1'b0;
        unique case (state)
            S_RD_X:  eng_addr = xp[AW-1:1];
            S_RD_CR: eng_addr = cp[AW-1:1];
            S_RD_CI: begin
                eng_addr  = cp_im[AW-1:1];
                mac_en_re = 1'b1;
            end
            S_MAC:   mac_en_im = 1'b1;
            S_WR_RE: begin
                eng_we    = 1'b1;
                eng_addr  = op[AW-1:1];
                eng_wdata = y_re;
            end
            S_WR_IM: begin
                eng_we    = 1'b1;
                eng_addr  = op_im[AW-1:1];
                eng_wdata = y_im;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cxfir_chk.sv
module cxfir_chk
    import cxfir_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [4:0]    opcode,
    input logic          busy,
    input logic          done,
    input logic          eng_we,
    input logic [AW-1:0] in_ptr_next,
    input logic [AW-1:0] out_ptr_next
);

    assert_bad_opcode_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode != OPC_CXFIR && !busy) |=> !busy);

    assert_write_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_we) |=> eng_we);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(eng_we));

    assert_ptrs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(in_ptr_next) && $stable(out_ptr_next)));

    assert_write_inside_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (busy && !done));

endmodule

bind cxfir_engine cxfir_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .opcode       (opcode),
    .busy         (busy),
    .done         (done),
    .eng_we       (eng_we),
    .in_ptr_next  (in_ptr_next),
    .out_ptr_next (out_ptr_next)
);

// File: tb/sim_cxfir_engine.sv
module sim_cxfir_engine;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    opcode = '0;
    logic [AW-1:0] coef_base = '0, in_base = '0, in_size = '0, in_ptr = '0;
    logic [AW-1:0] out_base = '0, out_size = '0, out_ptr = '0;
    logic [KW-1:0] tap_cnt = '0;
    logic          busy, done;
    logic [AW-1:0] in_ptr_next, out_ptr_next;
    logic          ext_we = 1'b0;
    logic [AW-2:0] ext_addr = '0;
    logic [DW-1:0] ext_wdata = '0;
    logic [DW-1:0] ext_rdata;

    cxfir_engine #(.AW(AW), .DW(DW), .KW(KW), .ACCW(40)) u0 (
        .clk, .rst_n, .start, .opcode, .coef_base, .tap_cnt,
        .in_base, .in_size, .in_ptr, .out_base, .out_size, .out_ptr,
        .busy, .done, .in_ptr_next, .out_ptr_next,
        .ext_we, .ext_addr, .ext_wdata, .ext_rdata
    );

    always #10ns clk = ~clk;

    typedef struct {
        int    inp;
        int    outp;
        int    lat;
        string tag;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    int          busy_cyc = 0;
    logic [15:0] shadow [512];

    task automatic check(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int rnd_sat(longint acc);
        longint s;
        s = (acc + 64'sd16384) >>> 15;
        if (s > 32767)  return 32767;
        if (s < -32768) return -32768;
        return int'(s);
    endfunction

    // Monitor: pops the scoreboard at each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin : mon_pop
                exp_t e;
                if (exp_q.size() == 0) begin
                    check("R10", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check("R7", {e.tag, " in_ptr_next"}, int'(in_ptr_next), e.inp);
                    check("R6", {e.tag, " out_ptr_next"}, int'(out_ptr_next), e.outp);
                    check("R11", {e.tag, " busy cycles"}, busy_cyc, e.lat);
                end
                busy_cyc = 0;
                done_cnt++;
            end else if (busy) begin
                busy_cyc++;
            end
        end
    end

    task automatic mem_wr(int a, int d);
        @(negedge clk);
        ext_we    = 1'b1;
        ext_addr  = (AW-1)'(a >> 1);
        ext_wdata = d[15:0];
        @(negedge clk);
        ext_we = 1'b0;
        shadow[a >> 1] = d[15:0];
    endtask

    task automatic mem_rd(int a, output int d);
        @(negedge clk);
        ext_addr = (AW-1)'(a >> 1);
        @(negedge clk);
        d = int'($signed(ext_rdata));
    endtask

    // Driver: computes expectations, pushes them, launches, then checks memory
    task automatic run(string tag, int cb, int k, int ib, int im, int ip,
                       int ob, int on, int op, bit glitch);
        longint ar = 0, ai = 0;
        int     ere, eim, got, d0, n;
        exp_t   e;
        for (int p = 0; p < k; p++) begin
            int a;
            a = ip - 2 * p;
            while (a < ib) a += im + 1;
            ar += longint'($signed(shadow[a >> 1])) * longint'($signed(shadow[(cb + 4 * p) >> 1]));
            ai += longint'($signed(shadow[a >> 1])) * longint'($signed(shadow[(cb + 4 * p + 2) >> 1]));
        end
        ere    = rnd_sat(ar);
        eim    = rnd_sat(ai);
        e.inp  = (ip + 2 > ib + im) ? ib : ip + 2;
        e.outp = (op + 4 > ob + on) ? ob : op + 4;
        e.lat  = 4 * k + 2;
        e.tag  = tag;
        exp_q.push_back(e);
        d0 = done_cnt;
        @(negedge clk);
        opcode = 5'b00101; coef_base = AW'(cb); tap_cnt = KW'(k);
        in_base = AW'(ib); in_size = AW'(im); in_ptr = AW'(ip);
        out_base = AW'(ob); out_size = AW'(on); out_ptr = AW'(op);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            // R10: second start while busy, aimed at a different output slot
            repeat (2) @(negedge clk);
            out_ptr = AW'(10'h248);
            tap_cnt = KW'(1);
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (done_cnt == d0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R8", {tag, " done seen"}, int'(done_cnt != d0), 1);
        mem_rd(op, got);
        check("R2", {tag, " R5 real word"}, got, ere);
        mem_rd(op + 2, got);
        check("R2", {tag, " R5 imag word"}, got, eim);
        shadow[op >> 1]       = ere[15:0];
        shadow[(op + 2) >> 1] = eim[15:0];
    endtask

    // Watchdog
    initial begin
        #(200000 * 20ns);
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int v, pin, pout, bad;
        for (int i = 0; i < 512; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12", "busy after reset", int'(busy), 0);
        check("R12", "done after reset", int'(done), 0);
        check("R12", "in_ptr_next after reset", int'(in_ptr_next), 0);
        check("R12", "out_ptr_next after reset", int'(out_ptr_next), 0);

        // Coefficients at 0x000: real then imag per tap
        mem_wr(16'h000, 16'h4000); mem_wr(16'h002, 16'hC000);
        mem_wr(16'h004, 1200);     mem_wr(16'h006, -900);
        mem_wr(16'h008, -20000);   mem_wr(16'h00A, 7000);
        mem_wr(16'h00C, 32767);    mem_wr(16'h00E, -32768);
        mem_wr(16'h010, 5);        mem_wr(16'h012, 31000);
        mem_wr(16'h014, -15000);   mem_wr(16'h016, -15000);
        mem_wr(16'h018, 2500);     mem_wr(16'h01A, 99);
        mem_wr(16'h01C, -1);       mem_wr(16'h01E, 12345);
        // Input ring 0x100, M=15 (8 samples)
        mem_wr(16'h100, 1000);  mem_wr(16'h102, -2000);
        mem_wr(16'h104, 3000);  mem_wr(16'h106, 12000);
        mem_wr(16'h108, -32768); mem_wr(16'h10A, 32767);
        mem_wr(16'h10C, 500);   mem_wr(16'h10E, -7);
        // Output slots prefilled
        for (int a = 16'h200; a < 16'h210; a += 2) mem_wr(a, 16'h5A5A);
        mem_wr(16'h248, 16'h7777); mem_wr(16'h24A, 16'h7777);

        // R12: side-port latency
        mem_rd(16'h10E, v);
        check("R12", "side port read", v, -7);

        // R9: single tap
        run("R9 K1", 16'h000, 1, 16'h100, 15, 16'h104, 16'h200, 15, 16'h200, 1'b0);
        // R2: four taps, no wrap
        run("R2 K4", 16'h000, 4, 16'h100, 15, 16'h10C, 16'h200, 15, 16'h204, 1'b0);
        // R3: window crosses ring base
        run("R3 K6 wrap", 16'h000, 6, 16'h100, 15, 16'h104, 16'h200, 15, 16'h208, 1'b0);
        // R6 R7: newest sample at ring end, output on last slot
        run("R6 R7 K8 edges", 16'h000, 8, 16'h100, 15, 16'h10E, 16'h200, 15, 16'h20C, 1'b0);
        // R9: zero taps write zeros
        run("R9 K0", 16'h000, 0, 16'h100, 15, 16'h106, 16'h200, 15, 16'h200, 1'b0);

        // R4: saturation both directions
        mem_wr(16'h040, 16'h8000); mem_wr(16'h042, 16'h7FFF);
        mem_wr(16'h044, 16'h8000); mem_wr(16'h046, 16'h7FFF);
        mem_wr(16'h180, 16'h8000); mem_wr(16'h182, 16'h8000);
        run("R4 saturate", 16'h040, 2, 16'h180, 3, 16'h182, 16'h240, 7, 16'h240, 1'b0);
        // R4: rounding of half and above
        mem_wr(16'h060, 16'h4000); mem_wr(16'h062, 16'hC000);
        mem_wr(16'h1C0, 1);
        run("R4 round x1", 16'h060, 1, 16'h1C0, 1, 16'h1C0, 16'h240, 7, 16'h244, 1'b0);
        mem_wr(16'h1C0, 3);
        run("R4 round x3", 16'h060, 1, 16'h1C0, 1, 16'h1C0, 16'h240, 7, 16'h240, 1'b0);

        // R1: wrong opcode is ignored
        pin  = int'(in_ptr_next);
        pout = int'(out_ptr_next);
        @(negedge clk);
        opcode = 5'b00110; tap_cnt = KW'(2); out_ptr = AW'(16'h208);
        in_ptr = AW'(16'h100); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            if (busy || done) bad++;
            @(negedge clk);
        end
        check("R1", "busy or done after bad opcode", bad, 0);
        check("R1", "in_ptr_next held", int'(in_ptr_next), pin);
        check("R1", "out_ptr_next held", int'(out_ptr_next), pout);
        mem_rd(16'h208, v);
        check("R1", "output slot untouched", v, int'($signed(shadow[16'h208 >> 1])));

        // R10: start while busy has no effect
        run("R10 busy start", 16'h000, 3, 16'h100, 15, 16'h108, 16'h200, 15, 16'h200, 1'b1);
        repeat (20) @(negedge clk);
        mem_rd(16'h248, v);
        check("R10", "slot of ignored start untouched", v, 16'h7777);
        check("R10", "scoreboard drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule